// File: doc/BRIEF.md
# Compare Flags and Conditional Branch Resolver

This block resolves the compare instruction and the ten conditional branches of a 32-bit machine whose instructions are 16 bits wide. When the compare strobe is high, the two register operands are compared and the result is written into a 5-bit condition register at the next clock edge. Two kinds of flag are recorded together: signed ordering and unsigned ordering. An equal result is recorded on its own, with every ordering flag cleared.

A branch is presented as an 8-bit opcode, the PC of the branch and the 32-bit absolute target word that follows it. In the same cycle, the block tests the stored flags against the condition that the opcode selects. It reports whether the branch is taken and gives the next PC. That PC is the target when the branch is taken. Otherwise it is the address just past the instruction and its target word. Instruction fetch and the register file sit outside the block and feed it the operands and the target.

Top module: `cmpbr_unit`

## Requirements
- R1: While the reset is asserted, and until the internal synchronised reset is released, the condition register reads 5'b00000.
- R2: A compare of equal operands stores exactly 5'b00100, with bit 2 (equal) set and all other bits clear.
- R3: A compare of unequal operands clears bit 2. It sets bit 1 for signed less-than, bit 0 for signed greater-than, bit 4 for unsigned less-than and bit 3 for unsigned greater-than, all in the same update.
- R4: The condition register changes only at a clock edge where cmp_en_i is high; on every other edge it holds its value, whatever the opcode and operands.
- R5: The single-flag branches are taken as follows: 0x0F when bit 2 is set, 0x10 when bit 2 is clear, 0x11 on bit 1, 0x12 on bit 0, 0x13 on bit 4 and 0x14 on bit 3.
- R6: The compound branches are taken on a strict-ordering flag or the equal flag: 0x15 on bit 0 or bit 2, 0x16 on bit 1 or bit 2, 0x17 on bit 3 or bit 2, and 0x18 on bit 4 or bit 2.
- R7: A taken branch sets next_pc_o to target_i.
- R8: A branch opcode that is not taken sets next_pc_o to pc_i + 6, with modulo-2^32 wraparound.
- R9: Any opcode outside 0x0F..0x18 gives taken_o = 0 and next_pc_o = pc_i + 2.
- R10: A branch in the same cycle as a compare is resolved against the flags stored by the earlier compare, not the one in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| opcode_i | input | 8 | Opcode of the current instruction |
| cmp_en_i | input | 1 | Compare strobe; captures flags at the next edge |
| opnd_a_i | input | 32 | First compare operand |
| opnd_b_i | input | 32 | Second compare operand |
| target_i | input | 32 | Absolute branch target word |
| pc_i | input | 32 | PC of the current instruction |
| flags_o | output | 5 | Stored condition register |
| taken_o | output | 1 | Branch taken |
| next_pc_o | output | 32 | Resolved next PC |

## Verification
The hardest situation to reach is a compare and a branch in the same cycle, where the new flags disagree with the old ones for the branch being tested. The stimulus first stores one flag pattern, then raises the compare strobe together with a branch opcode, using operands that produce the opposite pattern. A wrong result then shows up in taken_o right away. Operand pairs are chosen so that signed and unsigned ordering disagree (for example -1 against 1, and 0x80000000 against 0x7fffffff), so every branch opcode sees both outcomes.

// File: rtl/cmpbr_pkg.sv
package cmpbr_pkg;
  localparam int FLAG_W = 5;
  localparam int FL_GT  = 0;
  localparam int FL_LT  = 1;
  localparam int FL_EQ  = 2;
  localparam int FL_GTU = 3;
  localparam int FL_LTU = 4;

  typedef logic [FLAG_W-1:0] flags_t;

  localparam logic [7:0] OPC_BR_FIRST = 8'h0F;
  localparam logic [7:0] OPC_BR_LAST  = 8'h18;

  typedef enum logic [3:0] {
    BR_EQ  = 4'd0,
    BR_NE  = 4'd1,
    BR_LT  = 4'd2,
    BR_GT  = 4'd3,
    BR_LTU = 4'd4,
    BR_GTU = 4'd5,
    BR_GE  = 4'd6,
    BR_LE  = 4'd7,
    BR_GEU = 4'd8,
    BR_LEU = 4'd9
  } br_kind_e;
endpackage

// File: rtl/cmpbr_rst_sync.sv
module cmpbr_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;
  logic [STAGES-1:0] sync_d;

  always_comb begin
    sync_d = {sync_q[STAGES-2:0], 1'b1};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= sync_d;
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/cmpbr_flag_gen.sv
module cmpbr_flag_gen
  import cmpbr_pkg::*;
#(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] opnd_a,
  input  logic [XLEN-1:0] opnd_b,
  output flags_t          flags
);
  // Index 0: signed comparator, index 1: unsigned comparator
  logic [1:0] lt_v;
  logic [1:0] gt_v;
  logic       eq_w;

  for (genvar g = 0; g < 2; g++) begin : g_cmp
    if (g == 0) begin : g_signed
      assign lt_v[g] = $signed(opnd_a) < $signed(opnd_b);
      assign gt_v[g] = $signed(opnd_a) > $signed(opnd_b);
    end else begin : g_unsigned
      assign lt_v[g] = opnd_a < opnd_b;
      assign gt_v[g] = opnd_a > opnd_b;
    end
  end

  assign eq_w = (opnd_a == opnd_b);

  always_comb begin
    flags         = '0;
    flags[FL_EQ]  = eq_w;
    flags[FL_GT]  = !eq_w && gt_v[0];
    flags[FL_LT]  = !eq_w && lt_v[0];
    flags[FL_GTU] = !eq_w && gt_v[1];
    flags[FL_LTU] = !eq_w && lt_v[1];
  end
endmodule

// File: rtl/cmpbr_flag_reg.sv
module cmpbr_flag_reg
  import cmpbr_pkg::*;
(
  input  logic   clk,
  input  logic   rst_n,
  input  logic   load_en,
  input  flags_t flags_in,
  output flags_t flags_q
);
  flags_t flags_d;

  always_comb begin
    flags_d = flags_q;
    if (load_en) flags_d = flags_in;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) flags_q <= '0;
    else        flags_q <= flags_d;
  end
endmodule

// File: rtl/cmpbr_branch_eval.sv
module cmpbr_branch_eval
  import cmpbr_pkg::*;
#(
  parameter int OPC_W = 8
) (
  input  logic [OPC_W-1:0] opcode,
  input  flags_t           flags,
  output logic             is_branch,
  output logic             take
);
  localparam logic [OPC_W-1:0] FIRST = OPC_W'(OPC_BR_FIRST);
  localparam logic [OPC_W-1:0] LAST  = OPC_W'(OPC_BR_LAST);

  logic [OPC_W-1:0] rel;
  br_kind_e         kind;

  assign is_branch = (opcode >= FIRST) && (opcode <= LAST);
  assign rel       = opcode - FIRST;
  assign kind      = br_kind_e'(rel[3:0]);

  always_comb begin
    take = 1'b0;
    if (is_branch) begin
      unique case (kind)
        BR_EQ:   take = flags[FL_EQ];
        BR_NE:   take = !flags[FL_EQ];
        BR_LT:   take = flags[FL_LT];
        BR_GT:   take = flags[FL_GT];
        BR_LTU:  take = flags[FL_LTU];
        BR_GTU:  take = flags[FL_GTU];
        BR_GE:   take = flags[FL_GT]  || flags[FL_EQ];
        BR_LE:   take = flags[FL_LT]  || flags[FL_EQ];
        BR_GEU:  take = flags[FL_GTU] || flags[FL_EQ];
        BR_LEU:  take = flags[FL_LTU] || flags[FL_EQ];
        default: take = 1'b0;
      endcase
    end
  end
endmodule

// File: rtl/cmpbr_unit.sv
module cmpbr_unit
  import cmpbr_pkg::*;
#(
  parameter int XLEN        = 32,
  parameter int OPC_W       = 8,
  parameter int INSN_BYTES  = 2,
  parameter int IMM_BYTES   = 4,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [OPC_W-1:0]  opcode_i,
  input  logic              cmp_en_i,
  input  logic [XLEN-1:0]   opnd_a_i,
  input  logic [XLEN-1:0]   opnd_b_i,
  input  logic [XLEN-1:0]   target_i,
  input  logic [XLEN-1:0]   pc_i,
  output logic [FLAG_W-1:0] flags_o,
  output logic              taken_o,
  output logic [XLEN-1:0]   next_pc_o
);
  localparam logic [XLEN-1:0] STEP_PLAIN  = XLEN'(INSN_BYTES);
  localparam logic [XLEN-1:0] STEP_BRANCH = XLEN'(INSN_BYTES + IMM_BYTES);

  logic            rst_sync_n;
  flags_t          cmp_flags;
  flags_t          flags_q;
  logic            is_branch;
  logic            take;
  logic [XLEN-1:0] fall_pc;

  cmpbr_rst_sync #(.STAGES(SYNC_STAGES)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_sync_n)
  );

  cmpbr_flag_gen #(.XLEN(XLEN)) u_gen (
    .opnd_a (opnd_a_i),
    .opnd_b (opnd_b_i),
    .flags  (cmp_flags)
  );

  cmpbr_flag_reg u_reg (
    .clk      (clk),
    .rst_n    (rst_sync_n),
    .load_en  (cmp_en_i),
    .flags_in (cmp_flags),
    .flags_q  (flags_q)
  );

  cmpbr_branch_eval #(.OPC_W(OPC_W)) u_eval (
    .opcode    (opcode_i),
    .flags     (flags_q),
    .is_branch (is_branch),
    .take      (take)
  );

  assign fall_pc   = pc_i + (is_branch ? STEP_BRANCH : STEP_PLAIN);
  assign next_pc_o = take ? target_i : fall_pc;
  assign taken_o   = take;
  assign flags_o   = flags_q;
endmodule

// File: rtl/cmpbr_chk.sv
module cmpbr_chk #(
  parameter int XLEN  = 32,
  parameter int OPC_W = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             rst_ok,
  input logic [OPC_W-1:0] opcode_i,
  input logic             cmp_en_i,
  input logic [XLEN-1:0]  opnd_a_i,
  input logic [XLEN-1:0]  opnd_b_i,
  input logic [XLEN-1:0]  target_i,
  input logic [XLEN-1:0]  pc_i,
  input logic [4:0]       flags_o,
  input logic             taken_o,
  input logic [XLEN-1:0]  next_pc_o
);
  logic br_w;
  assign br_w = (opcode_i >= OPC_W'(8'h0F)) && (opcode_i <= OPC_W'(8'h18));

  // R1
  a_r1_reset_clear: assert property (@(posedge clk)
    $past(!rst_n) |-> flags_o == 5'b0);

  // R2
  a_r2_equal_only: assert property (@(posedge clk) disable iff (!rst_ok)
    $past(cmp_en_i && (opnd_a_i == opnd_b_i)) |-> flags_o == 5'b00100);

  // R3
  a_r3_one_per_kind: assert property (@(posedge clk) disable iff (!rst_ok)
    $past(cmp_en_i && (opnd_a_i != opnd_b_i)) |->
      (!flags_o[2] && $countones(flags_o[1:0]) == 1 && $countones(flags_o[4:3]) == 1));

  // R4
  a_r4_hold: assert property (@(posedge clk) disable iff (!rst_ok)
    !$past(cmp_en_i) |-> $stable(flags_o));

  // R5
  a_r5_ne_inverse: assert property (@(posedge clk) disable iff (!rst_ok)
    (opcode_i == OPC_W'(8'h10)) |-> (taken_o == !flags_o[2]));

  // R7
  a_r7_taken_target: assert property (@(posedge clk) disable iff (!rst_ok)
    taken_o |-> next_pc_o == target_i);

  // R8
  a_r8_fall_through: assert property (@(posedge clk) disable iff (!rst_ok)
    (br_w && !taken_o) |-> next_pc_o == pc_i + XLEN'(6));

  // R9
  a_r9_non_branch: assert property (@(posedge clk) disable iff (!rst_ok)
    !br_w |-> (!taken_o && next_pc_o == pc_i + XLEN'(2)));
endmodule

bind cmpbr_unit cmpbr_chk #(.XLEN(XLEN), .OPC_W(OPC_W)) chk_i (
  .clk       (clk),
  .rst_n     (rst_n),
  .rst_ok    (rst_sync_n),
  .opcode_i  (opcode_i),
  .cmp_en_i  (cmp_en_i),
  .opnd_a_i  (opnd_a_i),
  .opnd_b_i  (opnd_b_i),
  .target_i  (target_i),
  .pc_i      (pc_i),
  .flags_o   (flags_o),
  .taken_o   (taken_o),
  .next_pc_o (next_pc_o)
);

// File: tb/cmpbr_unit_tb_top.sv
`timescale 1ns/1ps
module cmpbr_unit_tb_top;
  logic        clk;
  logic        rst_n;
  logic [7:0]  opcode_i;
  logic        cmp_en_i;
  logic [31:0] opnd_a_i;
  logic [31:0] opnd_b_i;
  logic [31:0] target_i;
  logic [31:0] pc_i;
  logic [4:0]  flags_o;
  logic        taken_o;
  logic [31:0] next_pc_o;

  int    n_checks = 0;
  int    n_fails  = 0;
  bit    done     = 0;
  int    mflags   = 0;
  string ftag     = "R1";

  cmpbr_unit dut_i (
    .clk(clk), .rst_n(rst_n), .opcode_i(opcode_i), .cmp_en_i(cmp_en_i),
    .opnd_a_i(opnd_a_i), .opnd_b_i(opnd_b_i), .target_i(target_i),
    .pc_i(pc_i), .flags_o(flags_o), .taken_o(taken_o), .next_pc_o(next_pc_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input string tag, input string what, input longint act, input longint exp);
    n_checks++;
    if (act != exp) begin
      n_fails++;
      $display("FAIL %s %s: actual 0x%0h expected 0x%0h", tag, what, act, exp);
    end
  endtask

  function automatic int ref_flags(input logic [31:0] a, input logic [31:0] b);
    int f = 0;
    if (a == b) return 4;
    if ($signed(a) > $signed(b)) f += 1;
    if ($signed(a) < $signed(b)) f += 2;
    if (a > b) f += 8;
    if (a < b) f += 16;
    return f;
  endfunction

  function automatic bit ref_taken(input logic [7:0] op, input int f);
    case (op)
      8'h0F: return (f & 4) != 0;
      8'h10: return (f & 4) == 0;
      8'h11: return (f & 2) != 0;
      8'h12: return (f & 1) != 0;
      8'h13: return (f & 16) != 0;
      8'h14: return (f & 8) != 0;
      8'h15: return (f & 5) != 0;
      8'h16: return (f & 6) != 0;
      8'h17: return (f & 12) != 0;
      8'h18: return (f & 20) != 0;
      default: return 0;
    endcase
  endfunction

  task automatic step(input logic [7:0] op, input logic en, input logic [31:0] a,
                      input logic [31:0] b, input logic [31:0] tgt, input logic [31:0] pc,
                      input string otag);
    bit    br, tk;
    string ttag;
    logic [31:0] epc;
    @(negedge clk);
    chk(ftag, "flags", flags_o, mflags);
    opcode_i = op; cmp_en_i = en; opnd_a_i = a; opnd_b_i = b; target_i = tgt; pc_i = pc;
    #1;
    br = (op >= 8'h0F) && (op <= 8'h18);
    tk = ref_taken(op, mflags);
    if (otag != "") ttag = otag;
    else if (!br) ttag = "R9";
    else if (op >= 8'h15) ttag = "R6";
    else ttag = "R5";
    chk(ttag, "taken", taken_o, tk);
    epc = tk ? tgt : (br ? pc + 32'd6 : pc + 32'd2);
    chk(tk ? "R7" : (br ? "R8" : "R9"), "next_pc", next_pc_o, epc);
    @(posedge clk);
    if (en) begin
      mflags = ref_flags(a, b);
      ftag = (a == b) ? "R2" : "R3";
    end else if (ftag != "R1") ftag = "R4";
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst_n = 1'b0;
    cmp_en_i = 1'b1; opnd_a_i = 32'd1; opnd_b_i = 32'd2;
    mflags = 0; ftag = "R1";
    for (int i = 0; i < 3; i++) begin
      @(negedge clk);
      chk("R1", "flags in reset", flags_o, 0);
    end
    rst_n = 1'b1;
    for (int i = 0; i < 3; i++) step(8'h00, 1'b0, 32'd7, 32'd9, 32'h0, 32'h100, "");
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_fails++;
      $display("FAIL watchdog expired (R1..)");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] pa [6];
    logic [31:0] pb [6];
    logic [7:0]  nb [5];
    pa[0] = 32'd5;        pb[0] = 32'd5;
    pa[1] = 32'd5;        pb[1] = 32'd3;
    pa[2] = 32'hFFFFFFFF; pb[2] = 32'd1;
    pa[3] = 32'h80000000; pb[3] = 32'h7FFFFFFF;
    pa[4] = 32'd0;        pb[4] = 32'hFFFFFFFF;
    pa[5] = 32'd3;        pb[5] = 32'd9;
    nb[0] = 8'h00; nb[1] = 8'h0E; nb[2] = 8'h19; nb[3] = 8'hFF; nb[4] = 8'h0A;

    rst_n = 1'b0; opcode_i = 8'h00; cmp_en_i = 1'b0;
    opnd_a_i = '0; opnd_b_i = '0; target_i = '0; pc_i = '0;
    do_reset();

    // R2 R3 R5 R6 R7 R8: every pair, every branch opcode
    for (int p = 0; p < 6; p++) begin
      step(8'h0E, 1'b1, pa[p], pb[p], 32'h0, 32'h200, "");
      for (int op = 8'h0F; op <= 8'h18; op++)
        step(8'(op), 1'b0, 32'h0, 32'h0, 32'h4000 + 32'(op), 32'h1000 + 32'(p * 64), "");
    end

    // R4: compare opcode without strobe, differing operands, flags must hold
    step(8'h0E, 1'b1, 32'd4, 32'd4, 32'h0, 32'h300, "");
    step(8'h0E, 1'b0, 32'd1, 32'd9, 32'h0, 32'h302, "");
    step(8'h15, 1'b0, 32'd9, 32'd1, 32'h500, 32'h304, "R4");

    // R9: non-branch opcodes, including wrap near top of address space
    for (int k = 0; k < 5; k++)
      step(nb[k], 1'b0, 32'd0, 32'd0, 32'hDEAD0000, 32'hFFFFFFFE - 32'(k * 2), "R9");
    step(8'h11, 1'b0, 32'd0, 32'd0, 32'h800, 32'hFFFFFFFC, "R8");

    // R10: branch with simultaneous compare giving the opposite outcome
    step(8'h0E, 1'b1, 32'd2, 32'd8, 32'h0, 32'h600, "");
    step(8'h12, 1'b1, 32'd8, 32'd2, 32'h900, 32'h602, "R10");
    step(8'h12, 1'b0, 32'd0, 32'd0, 32'h900, 32'h608, "R10");
    step(8'h0F, 1'b1, 32'd6, 32'd6, 32'hA00, 32'h60E, "R10");
    step(8'h0F, 1'b0, 32'd0, 32'd0, 32'hA00, 32'h614, "R10");

    // R1: reset mid-run clears stored flags
    step(8'h0E, 1'b1, 32'hFFFFFFFF, 32'd0, 32'h0, 32'h700, "");
    do_reset();
    step(8'h10, 1'b0, 32'd0, 32'd0, 32'hB00, 32'h720, "R1");

    @(negedge clk);
    chk(ftag, "flags final", flags_o, mflags);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
    $finish;
  end
endmodule